// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block sits in front of a DMA transfer engine and chooses which channel may move one element next. Each channel presents a configuration word and a remaining element count. The peripheral request lines arrive as two vectors, single and burst. A channel qualifies when it is switched on, not halted, and has elements left. It must also have the peripheral requests that its flow-control code calls for. Among the qualifying channels, the lowest-numbered one wins.

The winner is registered as a one-hot grant together with its index. The grant stays put until the engine reports that the element has moved. The arbiter then drops the grant for one cycle and scans again. A channel whose flow code asks for peripheral-controlled flow is never granted. Instead, the block raises a per-channel error flag for it.

Top module: `dma_req_arbiter`

## Requirements
- R1: A channel can be granted only when its configuration bit 0 (on) is 1 and bit 18 (halt) is 0.
- R2: Configuration bits 13:11 hold the flow code, bits 5:1 the source peripheral number and bits 10:6 the destination peripheral number. Flow code 0 needs no request line.
- R3: Flow code 1 needs the request line selected by the destination peripheral number to be active.
- R4: Flow code 2 needs the request line selected by the source peripheral number to be active.
- R5: Flow code 3 needs both the source and the destination request lines to be active.
- R6: A request line counts as active when the corresponding bit of the single or the burst vector is 1. A peripheral number at or above the number of lines (16) counts as inactive.
- R7: A channel whose 12-bit remaining count is zero is never granted.
- R8: A channel that is on, not halted and has a flow code from 4 to 7 is never granted. Its bit of flow_err_o is 1 on the cycle after such a configuration is presented, whatever its count and the global enable.
- R9: When several channels qualify, the lowest-numbered one is granted.
- R10: While ctrl_en_i is 0, grant_vld_o is 0 from the next cycle on, and no grant is issued.
- R11: A grant appears one cycle after a qualifying channel is presented. It holds unchanged, even if the inputs change, until elem_done_i is 1 at a clock edge. grant_vld_o is then 0 for one cycle, and arbitration resumes on the cycle after that.
- R12: grant_o is one-hot while grant_vld_o is 1 and all zeros otherwise. grant_idx_o is the index of the set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_en_i | input | 1 | Global controller enable |
| chan_cfg_i | input | N_CH*32 | Channel configuration words, channel c at bits 32c+31:32c |
| chan_cnt_i | input | N_CH*CNT_W | Remaining element counts, channel c at bits CNT_W*c+CNT_W-1:CNT_W*c |
| req_single_i | input | N_PERIPH | Single-request lines |
| req_burst_i | input | N_PERIPH | Burst-request lines |
| elem_done_i | input | 1 | Engine has finished the granted element |
| grant_o | output | N_CH | One-hot registered grant |
| grant_idx_o | output | IDX_W | Index of the granted channel |
| grant_vld_o | output | 1 | Grant is held |
| flow_err_o | output | N_CH | Per-channel unsupported flow-code flag |

## Verification
The hardest case to reach is a held grant that must ignore a better candidate. The channel is granted while a lower-numbered channel becomes eligible, and the grant must still wait for the done pulse. Afterwards comes exactly one idle cycle before the lower channel wins. The bench first grants channel 3 alone and then turns channel 0 on while the grant is held. It checks that the grant does not move, then pulses done and samples the idle cycle and the new grant on successive cycles. A second hard case is a channel with a bad flow code sitting at a higher priority than an eligible one. The bench checks that the flagged channel is skipped and the lower-priority channel is granted.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int CFG_W   = 32;
  localparam int EN_BIT  = 0;
  localparam int SRC_LSB = 1;
  localparam int DST_LSB = 6;
  localparam int FLW_LSB = 11;
  localparam int HLT_BIT = 18;

  typedef struct packed {
    logic       halt;
    logic [2:0] flow;
    logic [4:0] dst;
    logic [4:0] src;
    logic       en;
  } cfg_fields_t;

  function automatic cfg_fields_t unpack_cfg(logic [CFG_W-1:0] w);
    cfg_fields_t f;
    f.en   = w[EN_BIT];
    f.src  = w[SRC_LSB +: 5];
    f.dst  = w[DST_LSB +: 5];
    f.flow = w[FLW_LSB +: 3];
    f.halt = w[HLT_BIT];
    return f;
  endfunction
endpackage

// File: rtl/dma_chan_elig.sv
module dma_chan_elig
  import dma_arb_pkg::*;
#(
  parameter int N_PERIPH = 16,
  parameter int CNT_W    = 12
) (
  input  logic [CFG_W-1:0]    cfg_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [N_PERIPH-1:0] req_i,
  output logic                elig_o,
  output logic                flow_err_o
);
  cfg_fields_t f;
  logic [31:0] req_ext;
  logic active, src_on, dst_on, need_ok;
  logic unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_i[CFG_W-1:HLT_BIT+1], cfg_i[HLT_BIT-1:FLW_LSB+3]};
  assign f       = unpack_cfg(cfg_i);
  // lines above N_PERIPH read as zero
  assign req_ext = 32'(req_i);
  assign src_on  = req_ext[f.src];
  assign dst_on  = req_ext[f.dst];
  assign active  = f.en & ~f.halt;

  always_comb begin
    unique case (f.flow)
      3'd0:    need_ok = 1'b1;
      3'd1:    need_ok = dst_on;
      3'd2:    need_ok = src_on;
      3'd3:    need_ok = src_on & dst_on;
      default: need_ok = 1'b0;
    endcase
  end

  assign elig_o     = active & (cnt_i != '0) & ~f.flow[2] & need_ok;
  assign flow_err_o = active & f.flow[2];

  initial assert (N_PERIPH <= 32);
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     onehot_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o    = '0;
    onehot_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o    = IDX_W'(i);
        onehot_o = '0;
        onehot_o[i] = 1'b1;
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int N_CH     = 8,
  parameter int N_PERIPH = 16,
  parameter int CNT_W    = 12,
  localparam int IDX_W   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ctrl_en_i,
  input  logic [N_CH*CFG_W-1:0] chan_cfg_i,
  input  logic [N_CH*CNT_W-1:0] chan_cnt_i,
  input  logic [N_PERIPH-1:0]   req_single_i,
  input  logic [N_PERIPH-1:0]   req_burst_i,
  input  logic                  elem_done_i,
  output logic [N_CH-1:0]       grant_o,
  output logic [IDX_W-1:0]      grant_idx_o,
  output logic                  grant_vld_o,
  output logic [N_CH-1:0]       flow_err_o
);
  logic [N_PERIPH-1:0] req_any;
  logic [N_CH-1:0]     elig, err_c, pick_oh;
  logic [IDX_W-1:0]    pick_idx;
  logic                pick_any;
  logic [N_CH-1:0]     grant_q, err_q;
  logic [IDX_W-1:0]    idx_q;
  logic                vld_q;

  assign req_any = req_single_i | req_burst_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dma_chan_elig #(.N_PERIPH(N_PERIPH), .CNT_W(CNT_W)) u_elig (
      .cfg_i      (chan_cfg_i[c*CFG_W +: CFG_W]),
      .cnt_i      (chan_cnt_i[c*CNT_W +: CNT_W]),
      .req_i      (req_any),
      .elig_o     (elig[c]),
      .flow_err_o (err_c[c])
    );
  end

  dma_prio_pick #(.N(N_CH), .IDX_W(IDX_W)) u_pick (
    .req_i    (elig),
    .onehot_o (pick_oh),
    .idx_o    (pick_idx),
    .any_o    (pick_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= '0;
      idx_q   <= '0;
      vld_q   <= 1'b0;
      err_q   <= '0;
    end else begin
      err_q <= err_c;
      if (!ctrl_en_i) begin
        grant_q <= '0;
        idx_q   <= '0;
        vld_q   <= 1'b0;
      end else if (vld_q) begin
        if (elem_done_i) begin
          grant_q <= '0;
          idx_q   <= '0;
          vld_q   <= 1'b0;
        end
      end else if (pick_any) begin
        grant_q <= pick_oh;
        idx_q   <= pick_idx;
        vld_q   <= 1'b1;
      end
    end
  end

  assign grant_o     = grant_q;
  assign grant_idx_o = idx_q;
  assign grant_vld_o = vld_q;
  assign flow_err_o  = err_q;

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> $onehot(grant_q)); // R12
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_q |-> (grant_q == '0)); // R12
  AST_IDX_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> grant_q[idx_q]); // R12
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !elem_done_i && ctrl_en_i) |=> (vld_q && $stable(grant_q) && $stable(idx_q))); // R11
  AST_DONE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && elem_done_i) |=> !vld_q); // R11
  AST_EN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en_i |=> !vld_q); // R10
  AST_ERR_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_q) |-> ((grant_q & err_q) == '0)); // R8
endmodule

// File: tb/sim_dma_req_arbiter.sv
module sim_dma_req_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH = 8;
  localparam int NP   = 16;
  localparam int CW   = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_en = 1'b0, done = 1'b0;
  logic [31:0] cfg [N_CH];
  logic [CW-1:0] cnt [N_CH];
  logic [N_CH*32-1:0] cfg_flat;
  logic [N_CH*CW-1:0] cnt_flat;
  logic [NP-1:0] rs = '0, rb = '0;
  logic [N_CH-1:0] grant, ferr;
  logic [2:0] gidx;
  logic gvld;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int i = 0; i < N_CH; i++) begin
      cfg_flat[i*32 +: 32] = cfg[i];
      cnt_flat[i*CW +: CW] = cnt[i];
    end

  dma_req_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_en_i(ctrl_en),
    .chan_cfg_i(cfg_flat), .chan_cnt_i(cnt_flat),
    .req_single_i(rs), .req_burst_i(rb), .elem_done_i(done),
    .grant_o(grant), .grant_idx_o(gidx), .grant_vld_o(gvld), .flow_err_o(ferr)
  );

  function automatic logic [31:0] mk(logic en, logic hlt, logic [2:0] fl,
                                     logic [4:0] src, logic [4:0] dst);
    return (32'(hlt) << 18) | (32'(fl) << 11) | (32'(dst) << 6) | (32'(src) << 1) | 32'(en);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expect no grant (vld=0) or a grant on channel c
  task automatic chk_grant(string req, int c);
    if (c < 0) chk(req, {gvld, 8'(grant)}, {1'b0, 8'h00});
    else       chk(req, {gvld, 8'(grant), 5'(gidx)}, {1'b1, 8'(1 << c), 5'(c)});
  endtask

  task automatic clear_all();
    @(negedge clk);
    ctrl_en = 1'b0; done = 1'b0; rs = '0; rb = '0;
    for (int i = 0; i < N_CH; i++) begin cfg[i] = '0; cnt[i] = 12'd5; end
    @(negedge clk);
    ctrl_en = 1'b1;
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic t_reset();
    chk("R12 reset", {gvld, 8'(grant), 8'(ferr)}, '0);
  endtask

  task automatic t_en_halt();
    clear_all();
    cfg[2] = mk(1, 1, 0, 0, 0); step();
    chk_grant("R1 halted", -1);
    cfg[2] = mk(0, 0, 0, 0, 0); step();
    chk_grant("R1 off", -1);
    cfg[2] = mk(1, 0, 0, 0, 0); step();
    chk_grant("R1 on", 2);
  endtask

  task automatic t_flow0();
    clear_all();
    cfg[5] = mk(1, 0, 0, 9, 10); step();
    chk_grant("R2 flow0", 5);
  endtask

  task automatic t_flow1();
    clear_all();
    cfg[4] = mk(1, 0, 1, 3, 7); rs = 16'h0008; step();
    chk_grant("R3 src only", -1);
    rs = 16'h0080; step();
    chk_grant("R3 dst line", 4);
  endtask

  task automatic t_flow2();
    clear_all();
    cfg[1] = mk(1, 0, 2, 3, 7); rs = 16'h0080; step();
    chk_grant("R4 dst only", -1);
    rs = 16'h0008; step();
    chk_grant("R4 src line", 1);
  endtask

  task automatic t_flow3();
    clear_all();
    cfg[6] = mk(1, 0, 3, 2, 12); rs = 16'h1000; step();
    chk_grant("R5 one line", -1);
    rb = 16'h0004; step();
    chk_grant("R5 both lines", 6);
  endtask

  task automatic t_req_or();
    clear_all();
    cfg[0] = mk(1, 0, 1, 0, 20); rs = 16'hffff; rb = 16'hffff; step();
    chk_grant("R6 periph 20", -1);
    cfg[0] = mk(1, 0, 1, 0, 15); rs = '0; rb = 16'h8000; step();
    chk_grant("R6 burst only", 0);
  endtask

  task automatic t_cnt();
    clear_all();
    cfg[3] = mk(1, 0, 0, 0, 0); cnt[3] = '0; step();
    chk_grant("R7 count zero", -1);
  endtask

  task automatic t_err();
    clear_all();
    cfg[1] = mk(1, 0, 5, 0, 0); rs = 16'hffff; step();
    chk_grant("R8 bad flow", -1);
    chk("R8 flag", 32'(ferr), 32'h02);
    clear_all();
    cfg[1] = mk(1, 0, 4, 0, 0); cfg[3] = mk(1, 0, 0, 0, 0); step();
    chk_grant("R8 skip flagged", 3);
    chk("R8 flag2", 32'(ferr), 32'h02);
  endtask

  task automatic t_prio();
    clear_all();
    cfg[6] = mk(1, 0, 0, 0, 0); cfg[4] = mk(1, 0, 0, 0, 0); cfg[1] = mk(1, 0, 0, 0, 0);
    step();
    chk_grant("R9 lowest wins", 1);
  endtask

  task automatic t_global();
    clear_all();
    ctrl_en = 1'b0; cfg[2] = mk(1, 0, 0, 0, 0); step(); step();
    chk_grant("R10 disabled", -1);
    ctrl_en = 1'b1; step();
    chk_grant("R10 enabled", 2);
    ctrl_en = 1'b0; step();
    chk_grant("R10 drop held", -1);
  endtask

  task automatic t_hold();
    clear_all();
    cfg[3] = mk(1, 0, 0, 0, 0); step();
    chk_grant("R11 first", 3);
    cfg[0] = mk(1, 0, 0, 0, 0); step(); step();
    chk_grant("R11 held", 3);
    done = 1'b1; step(); done = 1'b0;
    chk_grant("R11 gap", -1);
    step();
    chk_grant("R11 rearb", 0);
  endtask

  initial begin
    for (int i = 0; i < N_CH; i++) begin cfg[i] = '0; cnt[i] = '0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_en_halt(); t_flow0(); t_flow1(); t_flow2(); t_flow3();
    t_req_or(); t_cnt(); t_err(); t_prio(); t_global(); t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule